// File: doc/BRIEF.md
# LED String Fault Supervisor

This block watches eight LED current-source channels and decides when each one has to be switched off. Comparators outside the block report two digital flags per channel: the channel current has reached its target, and the channel voltage sits above the short threshold. Global flags report output overvoltage, the lower and upper over-temperature levels, and enable. A one-cycle strobe marks every PWM period, and all fault time-outs are counted in these periods.

Each channel learns a "good" history. A channel becomes good once its current reaches target. A good channel whose current later falls below target is an open-circuit suspect. While overvoltage or the lower over-temperature flag is raised, every channel that has not yet been good is also an open suspect. A channel that shows a high voltage is a short suspect. A suspect is disabled only after it has stayed suspect through six PWM strobes, and a disabled channel stays off. If a short would disable a channel while three or more channels are already off, the whole block shuts down. The upper over-temperature flag also shuts the block down. A shutdown stops the boost and turns every channel off until enable is cycled.

The controller has four states. In IDLE enable is low and all history is cleared. In RUN the block supervises the channels. In THERM_TRIP it holds the thermal shutdown, and in CAP_TRIP it holds the shutdown caused by the channel cap. The transitions are:
- IDLE to RUN when enable is high.
- RUN to THERM_TRIP on the upper over-temperature flag; this transition takes priority.
- RUN to CAP_TRIP when a short disable meets the cap.
- Any state to IDLE when enable is low.

Top module: `led_fault_supervisor`

## Requirements
- R1: While enable is low, all channel enables are 0, boost_stop is 1 and fault_vec is 0. All good flags, counters and disable latches are cleared. On the first clock edge with enable high, the state becomes RUN: boost_stop drops to 0 and every channel enable not yet latched off is 1.
- R2: A channel is marked good at any RUN clock edge where its cur_ok is 1. A good channel with cur_ok at 0 is an open suspect. A channel that has never been good is not a suspect on cur_ok alone.
- R3: While ovp is 1, every enabled channel that has not been good is an open suspect. Channels already good are not affected by ovp.
- R4: While otp_low is 1, every enabled channel that has not been good is an open suspect, in the same way as R3.
- R5: A channel whose over_v input is 1 is a short suspect.
- R6: A channel that stops being a suspect at any clock edge has its time-out count reset to zero. It then needs six fresh strobes before it is disabled.
- R7: The time-out count advances only at clock edges where pwm_tick is 1. The 3-bit count saturates at 6. A suspect is disabled at the edge of its sixth counted strobe: its bit in fault_vec rises and its ch_en bit falls after that edge. Without strobes, no channel is ever disabled.
- R8: Disabling one channel leaves the enables and fault bits of all other channels unchanged.
- R9: A short disable that occurs while three or more channels are already disabled moves the block to CAP_TRIP. ch_en then reads 0, boost_stop reads 1, and both hold until enable goes low. A disable caused by an open suspect only disables that channel.
- R10: otp_high at a RUN edge moves the block to THERM_TRIP. After that edge ch_en reads 0 and boost_stop reads 1, and both hold after otp_high falls, until enable goes low.
- R11: A disabled channel is excluded from all further evaluation. Its fault_vec bit stays 1 and its ch_en bit stays 0 until enable goes low, whatever its flags do. Disabled channels count toward the cap in R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Block enable; low clears all history |
| pwm_tick | input | 1 | One-cycle strobe per PWM period |
| cur_ok | input | 8 | Per-channel current-at-target flags |
| over_v | input | 8 | Per-channel voltage-above-short-threshold flags |
| ovp | input | 1 | Output overvoltage flag |
| otp_low | input | 1 | Lower over-temperature flag |
| otp_high | input | 1 | Upper over-temperature flag |
| ch_en | output | 8 | Per-channel current-source enables |
| boost_stop | output | 1 | Stop boost switching |
| fault_vec | output | 8 | Per-channel disabled-by-fault latches |

## Verification
A channel disable shows up on ch_en and fault_vec right after the clock edge of the sixth strobe that finds the channel suspect. The checks therefore sample at the falling edge after that strobe, and also after the fifth strobe, where the channel must still be on. The enable rise, the shutdown on otp_high and the cap shutdown all take one register stage each. They are checked at the first falling edge after the triggering edge, and checked again many cycles later to confirm they are held. Good flags are learned one edge after the block enters RUN, so the bench spends one extra cycle before it applies any fault pattern.

// File: rtl/lfs_pkg.sv
package lfs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_THERM_TRIP,
        ST_CAP_TRIP
    } sup_state_t;
endpackage

// File: rtl/lfs_channel.sv
module lfs_channel #(
    parameter int TIMEOUT = 6,
    localparam int CNT_W = $clog2(TIMEOUT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    input  logic pwm_tick,
    input  logic cur_ok,
    input  logic over_v,
    input  logic condemn,
    output logic disabled,
    output logic req_short
);
    logic             good_q;
    logic [CNT_W-1:0] cnt_q;
    logic             open_sus;
    logic             short_sus;
    logic             pending;
    logic             expire;

    always_comb begin
        open_sus  = !disabled && ((good_q && !cur_ok) || (!good_q && condemn));
        short_sus = !disabled && over_v;
        pending   = open_sus || short_sus;
        expire    = run && pending && pwm_tick && (cnt_q == CNT_W'(TIMEOUT - 1));
        req_short = expire && short_sus;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            good_q   <= 1'b0;
            cnt_q    <= '0;
            disabled <= 1'b0;
        end else if (clr) begin
            good_q   <= 1'b0;
            cnt_q    <= '0;
            disabled <= 1'b0;
        end else if (run) begin
            if (cur_ok && !disabled)
                good_q <= 1'b1;
            if (!pending)
                cnt_q <= '0;
            else if (pwm_tick && cnt_q < CNT_W'(TIMEOUT))
                cnt_q <= cnt_q + 1'b1;
            if (expire)
                disabled <= 1'b1;
        end
    end
endmodule

// File: rtl/lfs_ctrl.sv
module lfs_ctrl
    import lfs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic       otp_high,
    input  logic       cap_hit,
    output sup_state_t state,
    output logic       run,
    output logic       boost_stop
);
    sup_state_t nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:       if (enable) nxt = ST_RUN;
            ST_RUN: begin
                if (!enable)       nxt = ST_IDLE;
                else if (otp_high) nxt = ST_THERM_TRIP;
                else if (cap_hit)  nxt = ST_CAP_TRIP;
            end
            ST_THERM_TRIP: if (!enable) nxt = ST_IDLE;
            ST_CAP_TRIP:   if (!enable) nxt = ST_IDLE;
            default:       nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        run        = (state == ST_RUN);
        boost_stop = (state != ST_RUN);
    end
endmodule

// File: rtl/led_fault_supervisor.sv
module led_fault_supervisor
    import lfs_pkg::*;
#(
    parameter int NUM_CH  = 8,
    parameter int TIMEOUT = 6,
    parameter int MAX_OFF = 3,
    localparam int POP_W  = $clog2(NUM_CH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              pwm_tick,
    input  logic [NUM_CH-1:0] cur_ok,
    input  logic [NUM_CH-1:0] over_v,
    input  logic              ovp,
    input  logic              otp_low,
    input  logic              otp_high,
    output logic [NUM_CH-1:0] ch_en,
    output logic              boost_stop,
    output logic [NUM_CH-1:0] fault_vec
);
    sup_state_t        state;
    logic              run;
    logic              cap_hit;
    logic [NUM_CH-1:0] dis;
    logic [NUM_CH-1:0] sreq;
    logic [POP_W-1:0]  off_cnt;

    function automatic logic [POP_W-1:0] count_ones(input logic [NUM_CH-1:0] v);
        logic [POP_W-1:0] n;
        n = '0;
        for (int k = 0; k < NUM_CH; k++)
            n = n + POP_W'(v[k]);
        return n;
    endfunction

    genvar g;
    generate
        for (g = 0; g < NUM_CH; g++) begin : g_ch
            lfs_channel #(.TIMEOUT(TIMEOUT)) u_ch (
                .clk       (clk),
                .rst_n     (rst_n),
                .clr       (!enable),
                .run       (run),
                .pwm_tick  (pwm_tick),
                .cur_ok    (cur_ok[g]),
                .over_v    (over_v[g]),
                .condemn   (ovp || otp_low),
                .disabled  (dis[g]),
                .req_short (sreq[g])
            );
        end
    endgenerate

    always_comb begin
        off_cnt = count_ones(dis);
        cap_hit = (|sreq) && (off_cnt >= POP_W'(MAX_OFF));
    end

    lfs_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .otp_high   (otp_high),
        .cap_hit    (cap_hit),
        .state      (state),
        .run        (run),
        .boost_stop (boost_stop)
    );

    always_comb begin
        ch_en     = run ? ~dis : '0;
        fault_vec = dis;
    end
endmodule

// File: rtl/led_fault_supervisor_chk.sv
module led_fault_supervisor_chk #(
    parameter int NUM_CH = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enable,
    input logic              pwm_tick,
    input logic              otp_high,
    input logic [NUM_CH-1:0] ch_en,
    input logic              boost_stop,
    input logic [NUM_CH-1:0] fault_vec
);
    assert_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (fault_vec == '0 && boost_stop && ch_en == '0));

    assert_off_when_stopped_R10: assert property (@(posedge clk) disable iff (!rst_n)
        boost_stop |-> ch_en == '0);

    assert_therm_trip_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !boost_stop && otp_high) |=> boost_stop);

    assert_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        enable |=> ((fault_vec & $past(fault_vec)) == $past(fault_vec)));

    genvar g;
    generate
        for (g = 0; g < NUM_CH; g++) begin : g_a
            assert_disable_on_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(fault_vec[g]) |-> $past(pwm_tick));
        end
    endgenerate
endmodule

bind led_fault_supervisor led_fault_supervisor_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .pwm_tick   (pwm_tick),
    .otp_high   (otp_high),
    .ch_en      (ch_en),
    .boost_stop (boost_stop),
    .fault_vec  (fault_vec)
);

// File: tb/led_fault_supervisor_tb.sv
module led_fault_supervisor_tb;
    logic       clk = 0;
    logic       rst_n = 0;
    logic       enable = 0;
    logic       pwm_tick = 0;
    logic [7:0] cur_ok = 0;
    logic [7:0] over_v = 0;
    logic       ovp = 0;
    logic       otp_low = 0;
    logic       otp_high = 0;
    logic [7:0] ch_en;
    logic       boost_stop;
    logic [7:0] fault_vec;
    int         n_tests = 0;
    int         n_fail = 0;
    bit         done = 0;

    always #10 clk = ~clk;

    led_fault_supervisor u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .pwm_tick(pwm_tick),
        .cur_ok(cur_ok), .over_v(over_v), .ovp(ovp), .otp_low(otp_low),
        .otp_high(otp_high), .ch_en(ch_en), .boost_stop(boost_stop),
        .fault_vec(fault_vec)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_out(input string tag, input logic [7:0] e_en,
                           input logic eb, input logic [7:0] e_f);
        check(ch_en == e_en, {tag, " ch_en"}, ch_en, e_en);
        check(boost_stop == eb, {tag, " boost_stop"}, boost_stop, eb);
        check(fault_vec == e_f, {tag, " fault_vec"}, fault_vec, e_f);
    endtask

    task automatic cyc(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) begin
            pwm_tick = 1; @(negedge clk);
            pwm_tick = 0; @(negedge clk);
        end
    endtask

    task automatic restart(input logic [7:0] cur);
        enable = 0; over_v = 0; ovp = 0; otp_low = 0; otp_high = 0;
        pwm_tick = 0; cur_ok = cur;
        cyc(2);
        enable = 1;
        cyc(2);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++; n_tests++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        cyc(2);
        rst_n = 1;
        cyc(1);
        chk_out("R1 reset", 8'h00, 1'b1, 8'h00);

        restart(8'hFF);
        chk_out("R1 enable", 8'hFF, 1'b0, 8'h00);

        // R5 R7 R8 R11: short on each channel alone
        for (int i = 0; i < 8; i++) begin
            logic [7:0] m;
            m = 8'(1) << i;
            restart(8'hFF);
            over_v = m;
            ticks(5);
            chk_out("R7 five strobes", 8'hFF, 1'b0, 8'h00);
            ticks(1);
            chk_out("R5 R8 sixth strobe", ~m, 1'b0, m);
            over_v = 0; cur_ok = 8'hFF;
            ticks(8);
            chk_out("R11 sticky", ~m, 1'b0, m);
        end

        // R6: flag drops for one edge, count restarts
        restart(8'hFF);
        over_v = 8'h04;
        ticks(4);
        over_v = 0; cyc(1);
        over_v = 8'h04;
        ticks(5);
        chk_out("R6 after reset count", 8'hFF, 1'b0, 8'h00);
        ticks(1);
        chk_out("R6 expire", 8'hFB, 1'b0, 8'h04);

        // R7: no strobes, no disable
        restart(8'hFF);
        over_v = 8'h81;
        cyc(60);
        chk_out("R7 no strobe", 8'hFF, 1'b0, 8'h00);

        // R2: good learned, then lost; never-good channel untouched
        restart(8'h7F);
        cur_ok = 8'h5F;
        ticks(6);
        chk_out("R2 open of good", 8'hDF, 1'b0, 8'h20);
        ticks(6);
        chk_out("R2 never good ignored", 8'hDF, 1'b0, 8'h20);

        // R3: ovp condemns not-good channels
        restart(8'h0F);
        ovp = 1;
        ticks(5);
        chk_out("R3 pre", 8'hFF, 1'b0, 8'h00);
        ticks(1);
        chk_out("R3 ovp", 8'h0F, 1'b0, 8'hF0);

        // R4: lower over-temperature
        restart(8'h33);
        otp_low = 1;
        ticks(6);
        chk_out("R4 otp_low", 8'h33, 1'b0, 8'hCC);

        // R9: cap
        restart(8'hFF);
        over_v = 8'h07;
        ticks(6);
        chk_out("R9 three off", 8'hF8, 1'b0, 8'h07);
        over_v = 0; cur_ok = 8'hF7;
        ticks(6);
        chk_out("R9 open no cap", 8'hF0, 1'b0, 8'h0F);
        over_v = 8'h20;
        ticks(5);
        chk_out("R9 pre cap", 8'hF0, 1'b0, 8'h0F);
        ticks(1);
        check(ch_en == 8'h00 && boost_stop, "R9 cap trip", {boost_stop, ch_en}, 9'h100);
        over_v = 0; cur_ok = 8'hFF;
        cyc(20);
        check(ch_en == 8'h00 && boost_stop, "R9 cap held", {boost_stop, ch_en}, 9'h100);
        enable = 0; cyc(1);
        chk_out("R1 clear after cap", 8'h00, 1'b1, 8'h00);

        // R10: upper over-temperature
        restart(8'hFF);
        otp_high = 1; cyc(1);
        otp_high = 0;
        chk_out("R10 trip", 8'h00, 1'b1, 8'h00);
        ticks(10);
        chk_out("R10 held", 8'h00, 1'b1, 8'h00);
        enable = 0; cyc(1);
        enable = 1; cyc(1);
        chk_out("R10 R1 recover", 8'hFF, 1'b0, 8'h00);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule